// File: doc/BRIEF.md
# Configurable Alpha Blend Unit

This block mixes one source pixel into a destination pixel, one colour channel at a time. It takes a source ARGB8888 pixel, a framebuffer ARGB8888 pixel, a constant second colour and a coverage alpha, together with a set of mode bits. It produces the blended ARGB8888 pixel. Each colour channel is computed as source times a source factor plus destination times a destination factor. The value 255 stands for 1.0.

Each factor is built in two steps. First a select bit picks either 1.0 or the coverage alpha. Then an invert bit can replace that value with one minus the value. A further bit makes the destination the constant colour instead of the framebuffer pixel. The alpha channel works in one of two ways. In simple mode the written alpha is taken from one of four sources. In split mode the alpha channel is blended like the colour channels, but with its own pair of factor controls.

The unit has three pipeline stages and accepts one pixel per clock. A valid flag travels alongside each pixel. Framebuffer access, pixel format conversion and colour keying are handled elsewhere.

Top module: `abu_blend_top`

## Requirements
- R1: A synchronous reset drives `out_valid` low and `out_argb` to zero. Any pixels still in the pipeline at reset are discarded.
- R2: A pixel presented with `in_valid` high appears on the outputs exactly three clock edges later, with `out_valid` high for one cycle. The unit accepts a new pixel on every cycle.
- R3: The colour source factor is 255 when `src_fac_alpha` is 0 and `cov_alpha` when it is 1. When `src_fac_inv` is 1 the factor becomes 255 minus that value. The colour destination factor is formed the same way from `dst_fac_alpha` and `dst_fac_inv`.
- R4: Inverting a factor of 1.0 gives 0, so the matching operand adds nothing to the result.
- R5: When `dst_use_col2` is 1 the destination operand is `col2_argb`; otherwise it is `fb_argb`.
- R6: Each blended channel equals floor((s*Fs + d*Fd + 127) / 255), limited to a maximum of 255.
- R7: When `alpha_split` is 0, the output alpha is selected by `alpha_pick`: 00 gives the `col2_argb` alpha, 01 gives `cov_alpha`, 10 gives 0, and 11 gives the `fb_argb` alpha.
- R8: When `alpha_split` is 1, the output alpha is the R6 blend of the source alpha and the selected destination alpha. Its factors are built as in R3, but from `a_src_fac_alpha`, `a_src_fac_inv`, `a_dst_fac_alpha` and `a_dst_fac_inv`. In this mode `alpha_pick` has no effect.
- R9: All pixel buses use the layout A in bits 31:24, R in bits 23:16, G in bits 15:8 and B in bits 7:0. Alpha 0x00 means transparent and 0xFF means opaque.
- R10: On a cycle where `out_valid` is low, `out_argb` keeps the last value it showed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The input pixel and mode bits are valid this cycle |
| src_argb | input | 32 | Source pixel |
| fb_argb | input | 32 | Framebuffer pixel |
| col2_argb | input | 32 | Constant second colour |
| cov_alpha | input | 8 | Coverage alpha used for factors |
| src_fac_alpha | input | 1 | Colour source factor: 0 selects 1.0, 1 selects alpha |
| src_fac_inv | input | 1 | Invert the colour source factor |
| dst_fac_alpha | input | 1 | Colour destination factor: 0 selects 1.0, 1 selects alpha |
| dst_fac_inv | input | 1 | Invert the colour destination factor |
| dst_use_col2 | input | 1 | Use the constant colour as the destination |
| alpha_split | input | 1 | Blend the alpha channel with its own factors |
| a_src_fac_alpha | input | 1 | Alpha source factor select |
| a_src_fac_inv | input | 1 | Alpha source factor invert |
| a_dst_fac_alpha | input | 1 | Alpha destination factor select |
| a_dst_fac_inv | input | 1 | Alpha destination factor invert |
| alpha_pick | input | 2 | Alpha source in simple mode |
| out_valid | output | 1 | The result is valid |
| out_argb | output | 32 | Blended pixel |

## Verification
The bench drives every one of the 4096 combinations of the mode bits, back to back, using several pixel sets. Coverage values of 0 and 255 sit right where the one-minus inversion and the 1.0 select meet. If a design's inversion is off by one, or if it fails to zero an inverted 1.0, it leaves a residue in the channel.

A full sweep of the coverage alpha compares every rounded quotient against an exact division by 255. A design that divides by 256, or that leaves out the correction step, is wrong by one on many codes. A pair of operands whose sum exceeds 255 exposes a missing clamp, which shows up as a wrapped value.

Runs with gaps between pixels check that the output holds its value. A reset in the middle of a stream checks that pixels already in flight are dropped rather than leaking out later.

// File: rtl/abu_pkg.sv
package abu_pkg;
  localparam int ABU_CW  = 8;
  localparam int ABU_NCH = 4;

  typedef enum logic [1:0] {
    PICK_COL2 = 2'b00,
    PICK_COV  = 2'b01,
    PICK_ZERO = 2'b10,
    PICK_FB   = 2'b11
  } alpha_pick_e;
endpackage

// File: rtl/abu_factor.sv
module abu_factor #(
  parameter int CW = 8
) (
  input  logic          use_alpha,
  input  logic          invert,
  input  logic [CW-1:0] alpha,
  output logic [CW-1:0] fac
);
  logic [CW-1:0] base;

  always_comb begin
    base = use_alpha ? alpha : {CW{1'b1}};
    fac  = invert ? ~base : base;
  end
endmodule

// File: rtl/abu_lane.sv
module abu_lane #(
  parameter int CW = 8,
  localparam int PW = 2*CW + 1
) (
  input  logic          clk,
  input  logic [CW-1:0] s_val,
  input  logic [CW-1:0] d_val,
  input  logic [CW-1:0] s_fac,
  input  logic [CW-1:0] d_fac,
  output logic [PW-1:0] sum
);
  logic [2*CW-1:0] m_s, m_d;

  always_comb begin
    m_s = {{CW{1'b0}}, s_val} * {{CW{1'b0}}, s_fac};
    m_d = {{CW{1'b0}}, d_val} * {{CW{1'b0}}, d_fac};
  end

  always_ff @(posedge clk) begin
    sum <= {1'b0, m_s} + {1'b0, m_d};
  end
endmodule

// File: rtl/abu_norm.sv
module abu_norm #(
  parameter int CW = 8,
  localparam int PW = 2*CW + 1,
  localparam int MAXV = (1 << CW) - 1,
  localparam int HALF = MAXV >> 1,
  localparam int XW = PW + CW + 2
) (
  input  logic [PW-1:0] sum,
  output logic [CW-1:0] q
);
  logic [PW:0]   t, q0, q1, qc;
  logic [XW-1:0] chk;

  always_comb begin
    t   = {1'b0, sum} + (PW+1)'(HALF);
    q0  = (t + (t >> CW)) >> CW;
    q1  = q0 + 1'b1;
    chk = XW'(q1) * XW'(MAXV);
    qc  = (chk <= XW'(t)) ? q1 : q0;
    q   = (qc > (PW+1)'(MAXV)) ? CW'(MAXV) : qc[CW-1:0];
  end
endmodule

// File: rtl/abu_blend_top.sv
module abu_blend_top
  import abu_pkg::*;
#(
  parameter int CW  = ABU_CW,
  parameter int NCH = ABU_NCH,
  localparam int PXW = CW * NCH,
  localparam int PW  = 2*CW + 1,
  localparam int AL  = NCH - 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [PXW-1:0] src_argb,
  input  logic [PXW-1:0] fb_argb,
  input  logic [PXW-1:0] col2_argb,
  input  logic [CW-1:0]  cov_alpha,
  input  logic           src_fac_alpha,
  input  logic           src_fac_inv,
  input  logic           dst_fac_alpha,
  input  logic           dst_fac_inv,
  input  logic           dst_use_col2,
  input  logic           alpha_split,
  input  logic           a_src_fac_alpha,
  input  logic           a_src_fac_inv,
  input  logic           a_dst_fac_alpha,
  input  logic           a_dst_fac_inv,
  input  logic [1:0]     alpha_pick,
  output logic           out_valid,
  output logic [PXW-1:0] out_argb
);
  // factor generation (combinational, ahead of stage A)
  logic [CW-1:0] fs_col, fd_col, fs_alp, fd_alp;
  logic          as_sel, as_inv, ad_sel, ad_inv;

  always_comb begin
    as_sel = alpha_split ? a_src_fac_alpha : src_fac_alpha;
    as_inv = alpha_split ? a_src_fac_inv   : src_fac_inv;
    ad_sel = alpha_split ? a_dst_fac_alpha : dst_fac_alpha;
    ad_inv = alpha_split ? a_dst_fac_inv   : dst_fac_inv;
  end

  abu_factor #(.CW(CW)) u_fs_col (.use_alpha(src_fac_alpha), .invert(src_fac_inv),
                                  .alpha(cov_alpha), .fac(fs_col));
  abu_factor #(.CW(CW)) u_fd_col (.use_alpha(dst_fac_alpha), .invert(dst_fac_inv),
                                  .alpha(cov_alpha), .fac(fd_col));
  abu_factor #(.CW(CW)) u_fs_alp (.use_alpha(as_sel), .invert(as_inv),
                                  .alpha(cov_alpha), .fac(fs_alp));
  abu_factor #(.CW(CW)) u_fd_alp (.use_alpha(ad_sel), .invert(ad_inv),
                                  .alpha(cov_alpha), .fac(fd_alp));

  // simple-mode alpha choice
  logic [CW-1:0] picked;
  always_comb begin
    unique case (alpha_pick_e'(alpha_pick))
      PICK_COL2: picked = col2_argb[AL*CW +: CW];
      PICK_COV:  picked = cov_alpha;
      PICK_ZERO: picked = '0;
      PICK_FB:   picked = fb_argb[AL*CW +: CW];
      default:   picked = '0;
    endcase
  end

  logic [PXW-1:0] dst_sel;
  assign dst_sel = dst_use_col2 ? col2_argb : fb_argb;

  // stage A
  logic           a_valid, a_over;
  logic [CW-1:0]  a_pick;
  logic [PXW-1:0] a_src, a_dst;
  logic [CW-1:0]  a_fs_col, a_fd_col, a_fs_alp, a_fd_alp;

  always_ff @(posedge clk) begin
    if (rst) a_valid <= 1'b0;
    else     a_valid <= in_valid;
    a_over   <= ~alpha_split;
    a_pick   <= picked;
    a_src    <= src_argb;
    a_dst    <= dst_sel;
    a_fs_col <= fs_col;
    a_fd_col <= fd_col;
    a_fs_alp <= fs_alp;
    a_fd_alp <= fd_alp;
  end

  // stage B: per-lane multiply-add
  logic [PW-1:0] b_sum [NCH];
  logic          b_valid, b_over;
  logic [CW-1:0] b_pick;

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    logic [CW-1:0] lfs, lfd;
    if (i == AL) begin : g_alpha
      assign lfs = a_fs_alp;
      assign lfd = a_fd_alp;
    end else begin : g_colour
      assign lfs = a_fs_col;
      assign lfd = a_fd_col;
    end
    abu_lane #(.CW(CW)) u_lane (
      .clk  (clk),
      .s_val(a_src[i*CW +: CW]),
      .d_val(a_dst[i*CW +: CW]),
      .s_fac(lfs),
      .d_fac(lfd),
      .sum  (b_sum[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) b_valid <= 1'b0;
    else     b_valid <= a_valid;
    b_over <= a_over;
    b_pick <= a_pick;
  end

  // stage C: normalise, saturate, choose alpha
  logic [PXW-1:0] norm_px;

  for (genvar i = 0; i < NCH; i++) begin : g_norm
    logic [CW-1:0] nq;
    abu_norm #(.CW(CW)) u_norm (.sum(b_sum[i]), .q(nq));
    if (i == AL) begin : g_alpha
      assign norm_px[i*CW +: CW] = b_over ? b_pick : nq;
    end else begin : g_colour
      assign norm_px[i*CW +: CW] = nq;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_argb  <= '0;
    end else begin
      out_valid <= b_valid;
      if (b_valid) out_argb <= norm_px;
    end
  end
endmodule

// File: rtl/abu_blend_chk.sv
module abu_blend_chk #(
  parameter int PXW = 32,
  parameter int CW  = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           alpha_split,
  input logic [1:0]     alpha_pick,
  input logic           a_src_fac_alpha,
  input logic           a_src_fac_inv,
  input logic           a_dst_fac_alpha,
  input logic           a_dst_fac_inv,
  input logic           out_valid,
  input logic [PXW-1:0] out_argb
);
  logic [2:0] v_p, simple_zero_p, split_zero_p;
  logic       split_zero_now, simple_zero_now;

  assign simple_zero_now = !alpha_split && (alpha_pick == 2'b10);
  assign split_zero_now  = alpha_split && !a_src_fac_alpha && a_src_fac_inv &&
                           !a_dst_fac_alpha && a_dst_fac_inv;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_p           <= '0;
      simple_zero_p <= '0;
      split_zero_p  <= '0;
    end else begin
      v_p           <= {v_p[1:0], in_valid};
      simple_zero_p <= {simple_zero_p[1:0], simple_zero_now};
      split_zero_p  <= {split_zero_p[1:0], split_zero_now};
    end
  end

  // R1: the first cycle after reset shows a cleared output
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_argb == '0));

  // R2: output valid three edges after input valid
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == v_p[2]);

  // R7: the zero pick writes transparent alpha
  a_r7_zero_pick: assert property (@(posedge clk) disable iff (rst)
    (out_valid && simple_zero_p[2]) |-> out_argb[PXW-1 -: CW] == '0);

  // R4: both inverted unity factors give zero alpha
  a_r4_inverted_unity: assert property (@(posedge clk) disable iff (rst)
    (out_valid && split_zero_p[2]) |-> out_argb[PXW-1 -: CW] == '0);

  // R10: no update when nothing reaches the last stage
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !v_p[1] |=> $stable(out_argb));
endmodule

bind abu_blend_top abu_blend_chk #(.PXW(PXW), .CW(CW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .alpha_split    (alpha_split),
  .alpha_pick     (alpha_pick),
  .a_src_fac_alpha(a_src_fac_alpha),
  .a_src_fac_inv  (a_src_fac_inv),
  .a_dst_fac_alpha(a_dst_fac_alpha),
  .a_dst_fac_inv  (a_dst_fac_inv),
  .out_valid      (out_valid),
  .out_argb       (out_argb)
);

// File: tb/abu_blend_top_tb.sv
module abu_blend_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] src_argb = '0, fb_argb = '0, col2_argb = '0;
  logic [7:0]  cov_alpha = '0;
  logic        src_fac_alpha = 0, src_fac_inv = 0, dst_fac_alpha = 0, dst_fac_inv = 0;
  logic        dst_use_col2 = 0, alpha_split = 0;
  logic        a_src_fac_alpha = 0, a_src_fac_inv = 0, a_dst_fac_alpha = 0, a_dst_fac_inv = 0;
  logic [1:0]  alpha_pick = '0;
  logic        out_valid;
  logic [31:0] out_argb;

  int n_chk = 0, n_bad = 0;
  bit mon_en = 0;
  logic [31:0] last_out = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;

  abu_blend_top u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .src_argb(src_argb), .fb_argb(fb_argb), .col2_argb(col2_argb),
    .cov_alpha(cov_alpha),
    .src_fac_alpha(src_fac_alpha), .src_fac_inv(src_fac_inv),
    .dst_fac_alpha(dst_fac_alpha), .dst_fac_inv(dst_fac_inv),
    .dst_use_col2(dst_use_col2), .alpha_split(alpha_split),
    .a_src_fac_alpha(a_src_fac_alpha), .a_src_fac_inv(a_src_fac_inv),
    .a_dst_fac_alpha(a_dst_fac_alpha), .a_dst_fac_inv(a_dst_fac_inv),
    .alpha_pick(alpha_pick), .out_valid(out_valid), .out_argb(out_argb)
  );

  function automatic logic [31:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  function automatic int fac(input bit sel, input bit inv, input int a);
    int v;
    v = sel ? a : 255;
    return inv ? 255 - v : v;
  endfunction

  function automatic int blend(input int s, input int d, input int fs, input int fd);
    int r;
    r = (s * fs + d * fd + 127) / 255;
    return (r > 255) ? 255 : r;
  endfunction

  function automatic logic [31:0] model();
    logic [31:0] dst, r;
    int fs, fd;
    dst = dst_use_col2 ? col2_argb : fb_argb;
    fs = fac(src_fac_alpha, src_fac_inv, cov_alpha);
    fd = fac(dst_fac_alpha, dst_fac_inv, cov_alpha);
    for (int c = 0; c < 3; c++)
      r[c*8 +: 8] = 8'(blend(src_argb[c*8 +: 8], dst[c*8 +: 8], fs, fd));
    if (alpha_split)
      r[31:24] = 8'(blend(src_argb[31:24], dst[31:24],
                          fac(a_src_fac_alpha, a_src_fac_inv, cov_alpha),
                          fac(a_dst_fac_alpha, a_dst_fac_inv, cov_alpha)));
    else
      case (alpha_pick)
        2'b00:   r[31:24] = col2_argb[31:24];
        2'b01:   r[31:24] = cov_alpha;
        2'b10:   r[31:24] = 8'h00;
        default: r[31:24] = fb_argb[31:24];
      endcase
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic set_mode(input int m);
    src_fac_alpha   = m[0];
    src_fac_inv     = m[1];
    dst_fac_alpha   = m[2];
    dst_fac_inv     = m[3];
    dst_use_col2    = m[4];
    alpha_split     = m[5];
    a_src_fac_alpha = m[6];
    a_src_fac_inv   = m[7];
    a_dst_fac_alpha = m[8];
    a_dst_fac_inv   = m[9];
    alpha_pick      = 2'(m >> 10);
  endtask

  task automatic push(input string tag);
    in_valid = 1'b1;
    exp_q.push_back(model());
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: compares results in order, and checks hold when idle
  always @(negedge clk) begin
    if (mon_en) begin
      if (out_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected output", out_argb, 32'h0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_argb === e, t, out_argb, e);
        end
      end else begin
        check(out_argb === last_out, "R10 hold", out_argb, last_out);
      end
      last_out = out_argb;
    end
  end

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog", 32'h0, 32'h0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && out_argb == '0, "R1 reset state", {31'h0, out_valid} | out_argb, 32'h0);

    // R2: exact latency for a single pixel
    set_mode(0);
    src_argb = 32'h80402010; fb_argb = 32'h10203040; cov_alpha = 8'h33;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(!out_valid, "R2 early at +1", {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    check(!out_valid, "R2 early at +2", {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    check(out_valid && out_argb == model(), "R2 arrival at +3", out_argb, model());
    @(negedge clk);
    check(!out_valid, "R2 single pulse", {31'h0, out_valid}, 32'h0);
    last_out = out_argb;
    mon_en = 1'b1;

    // R3 R4 R5 R7 R8 R9: every mode combination, three pixel sets
    for (int p = 0; p < 3; p++) begin
      for (int m = 0; m < 4096; m++) begin
        set_mode(m);
        if (p == 0) begin
          src_argb = next_rand(); fb_argb = next_rand(); col2_argb = next_rand();
          cov_alpha = (m[1] ^ m[3]) ? 8'h00 : 8'hFF;
        end else begin
          src_argb = next_rand(); fb_argb = next_rand(); col2_argb = next_rand();
          cov_alpha = 8'(next_rand());
        end
        push("R3 R4 R5 R7 R8 R9 mode sweep");
      end
    end

    // R6: coverage sweep in source-over arrangement, then saturation
    set_mode(32'h00C | 32'h001);
    for (int a = 0; a < 256; a++) begin
      cov_alpha = 8'(a);
      src_argb = next_rand(); fb_argb = next_rand();
      push("R6 rounding sweep");
    end
    set_mode(0);
    src_argb = 32'hC0C0C0C0; fb_argb = 32'hC0C0C0C0;
    push("R6 saturation");
    src_argb = 32'h00FF0180; fb_argb = 32'h00010080;
    push("R6 saturation edge");

    // R10: sparse traffic with idle gaps
    for (int k = 0; k < 64; k++) begin
      set_mode(int'(next_rand() & 32'hFFF));
      src_argb = next_rand(); fb_argb = next_rand(); col2_argb = next_rand();
      cov_alpha = 8'(next_rand());
      push("R10 sparse traffic");
      repeat (int'(next_rand() & 32'h3)) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R2 lost output", 32'(exp_q.size()), 32'h0);

    // R1: reset in the middle of a stream drops pixels in flight
    mon_en = 1'b0;
    set_mode(0);
    src_argb = 32'hFFFFFFFF;
    in_valid = 1'b1;
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(!out_valid && out_argb == '0, "R1 mid-stream reset", out_argb, 32'h0);
    rst = 1'b0;
    exp_q.delete();
    tag_q.delete();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!out_valid, "R1 flushed pipeline", {31'h0, out_valid}, 32'h0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule